// File: doc/BRIEF.md
# Multi-Mode Effective Address Unit

This unit turns one load/store request into an effective memory address under one of eight addressing modes. It also returns the base-register update for the two self-modifying modes. The mode, two register operands, an immediate, a displacement-size code, a scale code and the current program counter are presented together with a request strobe. The result appears on registered outputs one clock later: the address, a writeback value with its enable, and an illegal-mode flag.

One mode dereferences a pointer. The unit raises a level request on a small request/response memory port, carrying the base value as the address. It reports busy until the response arrives, and then delivers the returned word as the final address. Requests presented while busy are discarded. All arithmetic is 32-bit and wraps.

Top module: `agu_top`

## Requirements
- R1: While reset is applied, `ea_valid_o`, `wb_en_o`, `illegal_o`, `busy_o` and `mem_req_o` are all low.
- R2: Mode code 0 gives base plus the low 16 bits of the immediate, sign-extended. The upper immediate bits are ignored and there is no writeback.
- R3: Mode code 1 gives the base value unchanged, with no writeback.
- R4: Mode code 2 gives base plus index, with no writeback.
- R5: Mode code 3 gives base + (index shifted left by the scale code 0..3) + displacement. The displacement is the sign-extended low 8 bits of the immediate for size code 0, the low 16 bits for size code 1, and the full immediate for size codes 2 and 3.
- R6: Mode code 4 gives the base as the address, with `wb_en_o` high and `wb_val_o` equal to base+1.
- R7: Mode code 5 gives base+immediate as the address, with `wb_en_o` high and `wb_val_o` equal to that same sum.
- R8: Mode code 7 gives the PC plus the immediate, with no writeback.
- R9: Mode code 6 raises `mem_req_o` and `busy_o` in the cycle after acceptance, with `mem_addr_o` equal to the base. Both stay high, with the address stable, until `mem_rsp_valid_i` is sampled. In the cycle after that, the result is the response word with no writeback. A response that arrives while idle is ignored.
- R10: A request presented while `busy_o` is high produces no result, and that includes the cycle in which the pointer response arrives.
- R11: Mode codes 8 to 15 produce a result with `illegal_o` high, address zero and `wb_en_o` low.
- R12: An accepted non-indirect request yields `ea_valid_o` for exactly the following cycle. Requests on consecutive cycles each yield their own result in order, and all sums wrap modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request strobe |
| mode_i | input | 4 | Addressing mode code |
| base_i | input | 32 | Base register value |
| index_i | input | 32 | Index register value |
| imm_i | input | 32 | Immediate / displacement |
| dsz_i | input | 2 | Displacement size code for scaled mode |
| scale_i | input | 2 | Index shift amount for scaled mode |
| pc_i | input | 32 | Current program counter |
| mem_rsp_valid_i | input | 1 | Pointer read response strobe |
| mem_rsp_data_i | input | 32 | Pointer read response word |
| busy_o | output | 1 | Pointer fetch outstanding |
| mem_req_o | output | 1 | Pointer read request (second memory access) |
| mem_addr_o | output | 32 | Pointer read address |
| ea_valid_o | output | 1 | Result valid |
| ea_addr_o | output | 32 | Effective address |
| wb_en_o | output | 1 | Base writeback enable |
| wb_val_o | output | 32 | Base writeback value |
| illegal_o | output | 1 | Unused mode code seen |

## Verification
The pointer response and a fresh request can meet in the same cycle. Busy is still high then, so the request must be dropped, while the pointer must still become the result in the next cycle. The bench provokes this by holding a writeback-mode request on the port while it returns the response. The scoreboard must then see exactly one result, the pointer with writeback low, and any extra result counts as a failure. Back-to-back requests are also driven, so that a result register loading on every cycle is judged in order.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned MODE_W  = 4;
  localparam int unsigned SCALE_W = 2;
  localparam int unsigned DSZ_W   = 2;
  localparam int unsigned NUM_DSZ = 3;

  typedef enum logic [MODE_W-1:0] {
    AM_DISP    = 4'd0,
    AM_REGIND  = 4'd1,
    AM_IDXBASE = 4'd2,
    AM_SCALED  = 4'd3,
    AM_POSTINC = 4'd4,
    AM_PREIDX  = 4'd5,
    AM_MEMIND  = 4'd6,
    AM_PCREL   = 4'd7
  } am_mode_e;

  typedef enum logic {
    PF_IDLE = 1'b0,
    PF_WAIT = 1'b1
  } pf_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              wb_en;
    logic [ADDR_W-1:0] wb_val;
    logic              illegal;
    logic              indirect;
  } agu_calc_t;
endpackage

// File: rtl/agu_disp_ext.sv
module agu_disp_ext
  import agu_pkg::*;
(
  input  logic [ADDR_W-1:0] imm_i,
  input  logic [DSZ_W-1:0]  dsz_i,
  output logic [ADDR_W-1:0] off16_o,
  output logic [ADDR_W-1:0] offsel_o
);
  logic [ADDR_W-1:0] ext [NUM_DSZ];

  // One sign-extender per supported size: 8, 16, 32 bits.
  for (genvar g = 0; g < NUM_DSZ; g++) begin : g_ext
    localparam int unsigned SH = ADDR_W - (8 << g);
    logic signed [ADDR_W-1:0] shl;
    assign shl    = $signed(imm_i << SH);
    assign ext[g] = shl >>> SH;
  end

  assign off16_o = ext[1];

  always_comb begin
    case (dsz_i)
      2'd0:    offsel_o = ext[0];
      2'd1:    offsel_o = ext[1];
      default: offsel_o = ext[2];
    endcase
  end
endmodule

// File: rtl/agu_calc.sv
module agu_calc
  import agu_pkg::*;
(
  input  logic [MODE_W-1:0]  mode_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [ADDR_W-1:0]  index_i,
  input  logic [ADDR_W-1:0]  imm_i,
  input  logic [DSZ_W-1:0]   dsz_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [ADDR_W-1:0]  pc_i,
  output agu_calc_t          res_o
);
  logic [ADDR_W-1:0] off16;
  logic [ADDR_W-1:0] offsel;
  logic [ADDR_W-1:0] scaled_idx;
  logic [ADDR_W-1:0] base_imm;

  agu_disp_ext u_ext (
    .imm_i    (imm_i),
    .dsz_i    (dsz_i),
    .off16_o  (off16),
    .offsel_o (offsel)
  );

  assign scaled_idx = index_i << scale_i;
  assign base_imm   = base_i + imm_i;

  always_comb begin
    res_o = '0;
    case (mode_i)
      AM_DISP:    res_o.addr = base_i + off16;
      AM_REGIND:  res_o.addr = base_i;
      AM_IDXBASE: res_o.addr = base_i + index_i;
      AM_SCALED:  res_o.addr = base_i + scaled_idx + offsel;
      AM_POSTINC: begin
        res_o.addr   = base_i;
        res_o.wb_en  = 1'b1;
        res_o.wb_val = base_i + 1'b1;
      end
      AM_PREIDX: begin
        res_o.addr   = base_imm;
        res_o.wb_en  = 1'b1;
        res_o.wb_val = base_imm;
      end
      AM_MEMIND: begin
        res_o.addr     = base_i;
        res_o.indirect = 1'b1;
      end
      AM_PCREL:   res_o.addr = pc_i + imm_i;
      default:    res_o.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/agu_ptr_fetch.sv
module agu_ptr_fetch
  import agu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] ptr_addr_i,
  input  logic              rsp_valid_i,
  input  logic [ADDR_W-1:0] rsp_data_i,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] ptr_o
);
  pf_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PF_IDLE: if (start_i)     state_d = PF_WAIT;
      PF_WAIT: if (rsp_valid_i) state_d = PF_IDLE;
      default:                  state_d = PF_IDLE;
    endcase
  end

  assign addr_en = start_i && (state_q == PF_IDLE);
  assign addr_d  = ptr_addr_i;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      state_q <= PF_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (addr_en) addr_q <= addr_d;
    end
  end

  assign busy_o     = (state_q == PF_WAIT);
  assign mem_req_o  = busy_o;
  assign mem_addr_o = addr_q;
  assign done_o     = busy_o && rsp_valid_i;
  assign ptr_o      = rsp_data_i;

  // R9: an outstanding read keeps its request and address until answered.
  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (mem_req_o && !rsp_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R10: a fetch is only launched from idle.
  p_start_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    start_i |-> !busy_o);
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_n_i,
  input  logic               req_valid_i,
  input  logic [MODE_W-1:0]  mode_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [ADDR_W-1:0]  index_i,
  input  logic [ADDR_W-1:0]  imm_i,
  input  logic [DSZ_W-1:0]   dsz_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic               mem_rsp_valid_i,
  input  logic [ADDR_W-1:0]  mem_rsp_data_i,
  output logic               busy_o,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic               ea_valid_o,
  output logic [ADDR_W-1:0]  ea_addr_o,
  output logic               wb_en_o,
  output logic [ADDR_W-1:0]  wb_val_o,
  output logic               illegal_o
);
  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= '0;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  agu_calc_t         calc;
  logic              accept;
  logic              launch_ind;
  logic              ptr_done;
  logic [ADDR_W-1:0] ptr_val;

  agu_calc u_calc (
    .mode_i  (mode_i),
    .base_i  (base_i),
    .index_i (index_i),
    .imm_i   (imm_i),
    .dsz_i   (dsz_i),
    .scale_i (scale_i),
    .pc_i    (pc_i),
    .res_o   (calc)
  );

  assign accept     = req_valid_i && !busy_o;
  assign launch_ind = accept && calc.indirect;

  agu_ptr_fetch u_fetch (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n),
    .start_i     (launch_ind),
    .ptr_addr_i  (calc.addr),
    .rsp_valid_i (mem_rsp_valid_i),
    .rsp_data_i  (mem_rsp_data_i),
    .busy_o      (busy_o),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .done_o      (ptr_done),
    .ptr_o       (ptr_val)
  );

  // Result register: next-state
  logic              res_load;
  logic              vld_d, wb_en_d, ill_d;
  logic [ADDR_W-1:0] addr_d, wb_val_d;
  logic              vld_q, wb_en_q, ill_q;
  logic [ADDR_W-1:0] addr_q, wb_val_q;

  always_comb begin
    res_load = (accept && !calc.indirect) || ptr_done;
    vld_d    = res_load;
    addr_d   = ptr_done ? ptr_val : calc.addr;
    wb_en_d  = accept && !calc.indirect && calc.wb_en;
    wb_val_d = calc.wb_val;
    ill_d    = accept && calc.illegal;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      vld_q    <= 1'b0;
      wb_en_q  <= 1'b0;
      ill_q    <= 1'b0;
      addr_q   <= '0;
      wb_val_q <= '0;
    end else begin
      vld_q   <= vld_d;
      wb_en_q <= wb_en_d;
      ill_q   <= ill_d;
      if (res_load) begin
        addr_q   <= addr_d;
        wb_val_q <= wb_val_d;
      end
    end
  end

  assign ea_valid_o = vld_q;
  assign ea_addr_o  = addr_q;
  assign wb_en_o    = wb_en_q;
  assign wb_val_o   = wb_val_q;
  assign illegal_o  = ill_q;

  // R10: while waiting without a response, no result is produced next cycle.
  p_busy_no_result_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    (busy_o && !mem_rsp_valid_i) |=> !ea_valid_o);

  // R9: a pointer response becomes the result one cycle later.
  p_ptr_result_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (busy_o && mem_rsp_valid_i) |=>
      (ea_valid_o && !wb_en_o && (ea_addr_o == $past(mem_rsp_data_i))));

  // R11: an illegal result never carries a writeback.
  p_illegal_no_wb_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    illegal_o |-> (ea_valid_o && !wb_en_o));

  // R6: post-increment writes back address plus one.
  p_postinc_wb_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (req_valid_i && !busy_o && (mode_i == AM_POSTINC)) |=>
      (wb_en_o && (wb_val_o == ea_addr_o + 1'b1)));

  // R12: writeback only ever accompanies a valid result.
  p_wb_with_valid_r12: assert property (@(posedge clk_i) disable iff (!rst_n)
    wb_en_o |-> ea_valid_o);
endmodule

// File: tb/agu_top_tb.sv
module agu_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [3:0]  mode;
  logic [31:0] base, index, imm, pc;
  logic [1:0]  dsz, scale;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        busy, mem_req, ea_valid, wb_en, illegal;
  logic [31:0] mem_addr, ea_addr, wb_val;

  always #5 clk = ~clk;

  agu_top u_dut (
    .clk_i(clk), .rst_n_i(rst_n), .req_valid_i(req_valid), .mode_i(mode),
    .base_i(base), .index_i(index), .imm_i(imm), .dsz_i(dsz), .scale_i(scale),
    .pc_i(pc), .mem_rsp_valid_i(rsp_valid), .mem_rsp_data_i(rsp_data),
    .busy_o(busy), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .ea_valid_o(ea_valid), .ea_addr_o(ea_addr), .wb_en_o(wb_en),
    .wb_val_o(wb_val), .illegal_o(illegal)
  );

  typedef struct {
    logic [31:0] addr;
    logic        wb_en;
    logic [31:0] wb_val;
    logic        ill;
    string       tag;
  } exp_t;

  exp_t sb[$];
  exp_t cur;
  int   n_chk = 0;
  int   n_bad = 0;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input logic [3:0] m, input logic [31:0] b,
      input logic [31:0] i, input logic [31:0] im, input logic [1:0] ds,
      input logic [1:0] sc, input logic [31:0] p, input string tag);
    exp_t e;
    logic [31:0] d;
    e.addr = 32'h0; e.wb_en = 1'b0; e.wb_val = 32'h0; e.ill = 1'b0; e.tag = tag;
    case (ds)
      2'd0:    d = {{24{im[7]}}, im[7:0]};
      2'd1:    d = {{16{im[15]}}, im[15:0]};
      default: d = im;
    endcase
    case (m)
      4'd0: e.addr = b + {{16{im[15]}}, im[15:0]};
      4'd1: e.addr = b;
      4'd2: e.addr = b + i;
      4'd3: e.addr = b + (i * (32'd1 << sc)) + d;
      4'd4: begin e.addr = b; e.wb_en = 1'b1; e.wb_val = b + 32'd1; end
      4'd5: begin e.addr = b + im; e.wb_en = 1'b1; e.wb_val = b + im; end
      4'd7: e.addr = p + im;
      default: e.ill = 1'b1;
    endcase
    return e;
  endfunction

  // Driver: present a request on the next negedge and queue its expectation.
  task automatic issue(input logic [3:0] m, input logic [31:0] b,
      input logic [31:0] i, input logic [31:0] im, input logic [1:0] ds,
      input logic [1:0] sc, input logic [31:0] p, input string tag);
    @(negedge clk);
    req_valid = 1'b1; mode = m; base = b; index = i; imm = im;
    dsz = ds; scale = sc; pc = p;
    if (m != 4'd6) sb.push_back(model(m, b, i, im, ds, sc, p, tag));
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: compare every produced result against the queue head.
  always @(negedge clk) begin
    if (rst_n && ea_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R10 unexpected result", ea_addr, 32'h0);
      end else begin
        cur = sb.pop_front();
        chk((ea_addr == cur.addr) && (wb_en == cur.wb_en) &&
            (!cur.wb_en || (wb_val == cur.wb_val)) && (illegal == cur.ill),
            cur.tag, ea_addr, cur.addr);
        if (cur.wb_en)
          chk(wb_val == cur.wb_val, {cur.tag, " wb"}, wb_val, cur.wb_val);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; mode = '0; base = '0; index = '0;
    imm = '0; dsz = '0; scale = '0; pc = '0; rsp_valid = 1'b0; rsp_data = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!ea_valid && !wb_en && !illegal, "R1 result quiet", {29'b0, ea_valid, wb_en, illegal}, 32'h0);
    chk(!busy && !mem_req, "R1 fetch quiet", {30'b0, busy, mem_req}, 32'h0);
    rst_n = 1'b1;
    idle(4);

    issue(4'd0, 32'h1000_0000, 32'h0, 32'h0000_FFF0, 2'd0, 2'd0, 32'h0, "R2 negative disp");
    issue(4'd0, 32'h1000_0000, 32'h0, 32'hFFFF_7FFF, 2'd0, 2'd0, 32'h0, "R2 upper bits ignored");
    issue(4'd1, 32'hDEAD_BEE0, 32'h5, 32'h77, 2'd0, 2'd0, 32'h0, "R3 register indirect");
    issue(4'd2, 32'h8000_0000, 32'h8000_0004, 32'h0, 2'd0, 2'd0, 32'h0, "R4 R12 wrap");
    issue(4'd3, 32'h0000_2000, 32'h10, 32'h0000_0080, 2'd0, 2'd3, 32'h0, "R5 scale8 disp8");
    issue(4'd3, 32'h0010_0000, 32'h0000_0300, 32'h0001_8000, 2'd1, 2'd1, 32'h0, "R5 scale2 disp16");
    issue(4'd3, 32'h0000_1000, 32'h0000_0004, 32'h1234_5678, 2'd2, 2'd2, 32'h0, "R5 scale4 disp32");
    issue(4'd3, 32'h0000_1000, 32'h0000_0007, 32'hFFFF_FF00, 2'd3, 2'd0, 32'h0, "R5 scale1 size3");
    issue(4'd4, 32'hFFFF_FFFF, 32'h0, 32'h0, 2'd0, 2'd0, 32'h0, "R6 post-increment wrap");
    issue(4'd5, 32'h0000_0100, 32'h0, 32'hFFFF_FFFC, 2'd0, 2'd0, 32'h0, "R7 pre-indexed");
    issue(4'd7, 32'h0, 32'h0, 32'h0000_0020, 2'd0, 2'd0, 32'h0000_0400, "R8 pc-relative");
    issue(4'd8, 32'h1234, 32'h0, 32'h0, 2'd0, 2'd0, 32'h0, "R11 code 8");
    issue(4'd15, 32'h5678, 32'h0, 32'h4, 2'd0, 2'd0, 32'h0, "R11 code 15");
    idle(2);

    // R9: pointer fetch
    issue(4'd6, 32'h0000_1000, 32'h0, 32'h0, 2'd0, 2'd0, 32'h0, "R9");
    @(negedge clk);
    chk(busy && mem_req, "R9 request raised", {30'b0, busy, mem_req}, 32'h3);
    chk(mem_addr == 32'h0000_1000, "R9 request address", mem_addr, 32'h0000_1000);
    // R10: request while busy is dropped
    req_valid = 1'b1; mode = 4'd0; base = 32'h9999_0000; imm = 32'h4;
    @(negedge clk);
    chk(!ea_valid, "R10 no result while busy", {31'b0, ea_valid}, 32'h0);
    @(negedge clk);
    chk(mem_req && (mem_addr == 32'h0000_1000), "R9 address held", mem_addr, 32'h0000_1000);
    // Response and a new writeback request in the same cycle
    rsp_valid = 1'b1; rsp_data = 32'hABCD_0040;
    mode = 4'd4; base = 32'h0000_0050;
    sb.push_back('{32'hABCD_0040, 1'b0, 32'h0, 1'b0, "R9 R10 pointer result"});
    @(negedge clk);
    rsp_valid = 1'b0; req_valid = 1'b0;
    chk(!busy && !mem_req, "R9 fetch complete", {30'b0, busy, mem_req}, 32'h0);
    @(negedge clk);
    chk(!ea_valid, "R10 same-cycle request dropped", {31'b0, ea_valid}, 32'h0);
    // Stray response while idle
    rsp_valid = 1'b1; rsp_data = 32'h5555_5555;
    @(negedge clk);
    rsp_valid = 1'b0;
    @(negedge clk);
    chk(!ea_valid && !busy, "R9 idle response ignored", {30'b0, ea_valid, busy}, 32'h0);

    issue(4'd5, 32'h0000_0200, 32'h0, 32'h0000_0010, 2'd0, 2'd0, 32'h0, "R7 after fetch");
    idle(3);
    chk(sb.size() == 0, "R12 all results delivered", sb.size(), 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule